// File: doc/BRIEF.md
# TDM Serial Frame Receiver

This block is the receive half of a time-division-multiplexed synchronous serial port. It watches a serial bit clock, a frame sync and one data line. On every falling edge of the bit clock it shifts one data bit, most significant bit first, into a shift register. When a time slot's word is complete, the word moves into a parallel receive data register. A data-ready flag then rises and, when enabled, an interrupt rises with it.

Every slot of a frame is captured, and there is no hardware slot masking. A slot-index output tells software which slot the held word came from, so software can drop the slots it does not need. If software misses a word, the next completed word overwrites it and an overrun flag is raised. A mode input chooses the clock and sync pair. The receiver can use its own pair, or it can share the transmitter's pair and run in lock step with the transmitter.

The serial inputs must already be synchronous to the system clock `clk`. The bit clock's high and low phases must each last at least one `clk` cycle.

Top module: `tdm_rx`

## Requirements
- R1: After reset, `ready`, `ovr` and `irq` are 0, and `rdata` and `rslot` are 0.
- R2: Data is sampled on each falling edge of the selected bit clock. It is taken most significant bit first. The completed word appears right-justified in `rdata`, with zeros above it. The word length follows `word_sel`: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 24.
- R3: A frame starts at the first falling edge where the sync input is 1 after being 0 at the previous falling edge. The bit sampled at that edge is the MSB of slot 0. Bits that arrive before the first frame start are ignored.
- R4: Every slot from 0 to `slots_m1` is captured, so a frame has `slots_m1`+1 slots. `rslot` gives the index of the slot the current `rdata` word came from.
- R5: After the last slot of a frame, incoming bits are ignored until the next frame start.
- R6: `ready` rises when a word completes and stays set until a `rd_data` pulse clears it.
- R7: `irq` is 1 exactly when `ready` is 1 and `ie` is 1.
- R8: A word can complete while `ready` is still set and no `rd_data` pulse occurs in that cycle. In that case `ovr` rises and the new word replaces the one in `rdata`.
- R9: Once set, `ovr` is cleared only by a `rd_stat` pulse followed by a later `rd_data` pulse. A `rd_data` pulse alone leaves it set.
- R10: When `sync_mode` is 0, `rx_bclk` and `rx_fsync` drive reception. When `sync_mode` is 1, `tx_bclk` and `tx_fsync` drive it. Activity on the unselected pair has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1: use transmitter clock and sync; 0: use own pair |
| rx_bclk | input | 1 | Receiver bit clock |
| rx_fsync | input | 1 | Receiver frame sync |
| tx_bclk | input | 1 | Transmitter bit clock |
| tx_fsync | input | 1 | Transmitter frame sync |
| sdata | input | 1 | Serial data line |
| word_sel | input | 2 | Word length code (8/12/16/24) |
| slots_m1 | input | 5 | Slots per frame minus one |
| ie | input | 1 | Receive interrupt enable |
| rd_stat | input | 1 | One-cycle status read strobe |
| rd_data | input | 1 | One-cycle data read strobe |
| rdata | output | 24 | Received word, right-justified |
| rslot | output | 5 | Slot index of the held word |
| ready | output | 1 | Data-ready flag |
| ovr | output | 1 | Receive overrun flag |
| irq | output | 1 | Receive interrupt |

## Verification
Some properties are checked on every cycle. The bit counter stays below the word length, and `ready` rises only on a bit-clock falling edge. `ready` and `ovr` fall only after a data read. `ovr` rises only while a word is still waiting. What only the bench scenarios can show is the data path itself: the word values across all four lengths and several frame sizes, the slot indices, idle bits being ignored before and between frames, the routing of the clock pair, and the two-step overrun clear.

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic              sdata,
  input  logic [1:0]        word_sel,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic              ie,
  input  logic              rd_stat,
  input  logic              rd_data,
  output logic [23:0]       rdata,
  output logic [SLOT_W-1:0] rslot,
  output logic              ready,
  output logic              ovr,
  output logic              irq
);
  localparam int MAXW = 24;

  logic [4:0]        wlen;
  logic              bclk_s, fs_s, bclk_q, fs_last;
  logic              fall, fs_rise, capture, done, set_ovr;
  logic              active, stat_seen;
  logic [4:0]        bit_cnt, eff_bit;
  logic [SLOT_W-1:0] slot_cnt, eff_slot;
  logic [MAXW-1:0]   shreg, shin, mask;

  always_comb begin
    case (word_sel)
      2'd0:    wlen = 5'd8;
      2'd1:    wlen = 5'd12;
      2'd2:    wlen = 5'd16;
      default: wlen = 5'd24;
    endcase
  end

  assign bclk_s   = sync_mode ? tx_bclk  : rx_bclk;
  assign fs_s     = sync_mode ? tx_fsync : rx_fsync;
  assign fall     = bclk_q & ~bclk_s;
  assign fs_rise  = fall & fs_s & ~fs_last;
  assign capture  = fall & (fs_rise | active);
  assign eff_bit  = fs_rise ? 5'd0 : bit_cnt;
  assign eff_slot = fs_rise ? '0 : slot_cnt;
  assign done     = capture & (eff_bit == wlen - 5'd1);
  assign shin     = {shreg[MAXW-2:0], sdata};
  assign mask     = ~({MAXW{1'b1}} << wlen);
  assign set_ovr  = done & ready & ~rd_data;
  assign irq      = ie & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      fs_last  <= 1'b0;
      active   <= 1'b0;
      bit_cnt  <= '0;
      slot_cnt <= '0;
      shreg    <= '0;
      rdata    <= '0;
      rslot    <= '0;
    end else begin
      bclk_q <= bclk_s;
      if (fall) fs_last <= fs_s;
      if (capture) begin
        shreg <= shin;
        if (done) begin
          bit_cnt <= '0;
          rdata   <= shin & mask;
          rslot   <= eff_slot;
          if (eff_slot == slots_m1) begin
            active   <= 1'b0;
            slot_cnt <= '0;
          end else begin
            active   <= 1'b1;
            slot_cnt <= eff_slot + 1'b1;
          end
        end else begin
          active   <= 1'b1;
          bit_cnt  <= eff_bit + 5'd1;
          slot_cnt <= eff_slot;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      ovr       <= 1'b0;
      stat_seen <= 1'b0;
    end else begin
      if (done)         ready <= 1'b1;
      else if (rd_data) ready <= 1'b0;

      if (set_ovr)                     ovr <= 1'b1;
      else if (rd_data && stat_seen)   ovr <= 1'b0;

      if (set_ovr || rd_data)  stat_seen <= 1'b0;
      else if (rd_stat && ovr) stat_seen <= 1'b1;
    end
  end

  p_bitcnt_in_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < wlen || !active);
  p_ready_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(fall));
  p_ready_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(rd_data));
  p_ovr_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(ready) && ready);
  p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(rd_data));
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);
endmodule

// File: tb/sim_tdm_rx.sv
module sim_tdm_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic rx_bclk = 1'b0, rx_fsync = 1'b0, tx_bclk = 1'b0, tx_fsync = 1'b0, sdata = 1'b0;
  logic [1:0] word_sel = 2'd0;
  logic [4:0] slots_m1 = 5'd0;
  logic ie = 1'b0, rd_stat = 1'b0, rd_data = 1'b0;
  logic [23:0] rdata;
  logic [4:0]  rslot;
  logic ready, ovr, irq;
  logic drive_tx = 1'b0;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  tdm_rx u0 (.clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .rx_bclk(rx_bclk),
    .rx_fsync(rx_fsync), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .sdata(sdata),
    .word_sel(word_sel), .slots_m1(slots_m1), .ie(ie), .rd_stat(rd_stat),
    .rd_data(rd_data), .rdata(rdata), .rslot(rslot), .ready(ready), .ovr(ovr), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic send_bit(input logic fs, input logic d);
    sdata = d;
    if (drive_tx) begin tx_bclk = 1'b1; tx_fsync = fs; end
    else          begin rx_bclk = 1'b1; rx_fsync = fs; end
    repeat (2) @(negedge clk);
    if (drive_tx) tx_bclk = 1'b0; else rx_bclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [23:0] w, input int len, input logic first);
    for (int b = len - 1; b >= 0; b--) send_bit(first && b == len - 1, w[b]);
  endtask

  task automatic pulse_data();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic pulse_stat();
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
  endtask

  function automatic int len_of(input int ws);
    return (ws == 0) ? 8 : (ws == 1) ? 12 : (ws == 2) ? 16 : 24;
  endfunction

  function automatic logic [23:0] val(input int ws, input int slot, input int fr);
    logic [31:0] h;
    h = (32'(slot) * 32'd37 + 32'(fr) * 32'd91 + 32'(ws) * 32'd13 + 32'd5) * 32'h9E3779B1;
    h = h ^ (h >> 13);
    return h[23:0] & ~(24'hFFFFFF << len_of(ws));
  endfunction

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", ready, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 rslot", rslot, 0);

    send_word(24'hA5, 8, 1'b0);
    chk("R3 pre-sync bits ignored", ready, 0);

    for (int ws = 0; ws < 4; ws++) begin
      for (int sm = 0; sm <= 4; sm += 2) begin
        word_sel = 2'(ws);
        slots_m1 = 5'(sm);
        ie = ws[0];
        for (int fr = 0; fr < 2; fr++) begin
          for (int s = 0; s <= sm; s++) begin
            send_word(val(ws, s, fr), len_of(ws), s == 0);
            chk("R6 ready set", ready, 1);
            chk("R2 rdata word", rdata, val(ws, s, fr));
            chk("R4 slot index", rslot, s);
            chk("R7 irq", irq, ws[0]);
            pulse_data();
            chk("R6 ready cleared", ready, 0);
            chk("R7 irq cleared", irq, 0);
            chk("R8 no overrun", ovr, 0);
          end
        end
      end
    end

    word_sel = 2'd0; slots_m1 = 5'd0; ie = 1'b1;
    send_word(24'h3C, 8, 1'b1);
    pulse_data();
    send_word(24'hFF, 8, 1'b0);
    chk("R5 bits after last slot ignored", ready, 0);
    send_word(24'h81, 8, 1'b1);
    chk("R5 next frame captured", rdata, 24'h81);
    pulse_data();

    slots_m1 = 5'd2;
    send_word(24'h11, 8, 1'b1);
    send_word(24'h22, 8, 1'b0);
    chk("R8 overrun set", ovr, 1);
    chk("R8 word overwritten", rdata, 24'h22);
    chk("R8 slot of new word", rslot, 1);
    pulse_data();
    chk("R9 data read alone keeps ovr", ovr, 1);
    chk("R6 ready cleared on overrun read", ready, 0);
    pulse_stat();
    chk("R9 status read alone keeps ovr", ovr, 1);
    pulse_data();
    chk("R9 status then data clears ovr", ovr, 0);
    send_word(24'h33, 8, 1'b0);
    chk("R9 slot 2 after clear", rslot, 2);
    pulse_data();

    slots_m1 = 5'd0; sync_mode = 1'b0; drive_tx = 1'b1;
    send_word(24'h5A, 8, 1'b1);
    chk("R10 tx pair ignored when sync_mode=0", ready, 0);
    sync_mode = 1'b1;
    send_word(24'h00, 8, 1'b0);
    send_word(24'hC3, 8, 1'b1);
    chk("R10 tx pair used when sync_mode=1", rdata, 24'hC3);
    chk("R10 ready via tx pair", ready, 1);
    pulse_data();
    drive_tx = 1'b0;
    send_word(24'h96, 8, 1'b1);
    chk("R10 rx pair ignored when sync_mode=1", ready, 0);

    finish_run();
  end
endmodule